// File: doc/BRIEF.md
# UART boot image RAM loader

This block sits between a serial receive line and the write port of a program RAM. During normal operation it listens to the line and lets the attached processor run. When a fixed nine-character ASCII unlock string arrives, it takes over the processor's active-low reset. It then reads a 32-bit word count and that many 32-bit data words. Each completed word goes out on a single-cycle write strobe, at consecutive word addresses starting from a fixed base. After the final word and a programmable settling delay, it releases reset and returns to listening.

The bit-level receiver is built in. It uses 8 data bits, no parity and one stop bit, LSB first. It has its own baud timing derived from the clock frequency and the baud rate parameters. The unlock string, base address, word width, settling delay and input synchroniser depth are parameters.

Top module: `uart_boot_loader`

## Requirements
- R1: While idle, a received byte equal to the first character of the unlock string starts string matching. From the next clock, `busy_o` is 1 and `sys_rst_no` is 0.
- R2: During matching, a byte that differs from the expected character of the unlock string returns the block to idle. Reset is released and no write strobe is issued.
- R3: After the last unlock character, the next four bytes form the word count N, least significant byte first. Exactly N write strobes follow.
- R4: Each data word is built from four received bytes, least significant byte first. Its value appears on `ram_wdata_o` with the strobe.
- R5: The first write of every load goes to address 0x8000_0000. Each later write of the same load goes to the previous address plus 4.
- R6: `ram_we_o` is high for exactly one clock per completed word and is never high while `busy_o` is 0.
- R7: `sys_rst_no` stays 0 from the start of matching until FINISH_DELAY (default 16) clocks after the clock in which the last write strobe of a load was issued. At that point it returns to 1.
- R8: `busy_o` is 1 exactly when the controller is not idle, and `sys_rst_no` is always its inverse.
- R9: The receiver samples each bit at its centre, LSB first. A low pulse on the line shorter than half a bit period is dropped as a false start and delivers no byte.
- R10: A frame whose stop bit samples low is discarded, and the matching position does not advance.
- R11: A word count of zero produces no write strobe. The block returns to idle after the settling delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uart_rx_i | input | 1 | Serial receive line, idle high |
| ram_we_o | output | 1 | One-clock write strobe per completed word |
| ram_addr_o | output | ADDR_W | Word write address |
| ram_wdata_o | output | WORD_W | Assembled write data |
| sys_rst_no | output | 1 | Active-low reset for the attached processor |
| busy_o | output | 1 | High while any part of a load is in progress |

## Verification
Two full loads with different counts and data are sent back to back. This separates correct address reload and little-endian assembly from stale state carried between loads. A zero count and an unlock string broken after three characters show whether writes or reset leak out of aborted or empty transfers. Loads interrupted by a short glitch and by a frame with a low stop bit complete only if the receiver drops both. A receiver that delivers a spurious byte breaks the string and produces no writes. The settling delay is measured in clocks from the last strobe of each load to the rising edge of the reset output.

// File: rtl/ubl_pkg.sv
package ubl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KEY,
      ST_COUNT,
      ST_LOAD,
      ST_DRAIN
   } ld_state_e;

   typedef enum logic [1:0] {
      RX_WAIT,
      RX_START,
      RX_BITS,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/ubl_rx.sv
module ubl_rx
   import ubl_pkg::*;
#(
   parameter int CLKS_PER_BIT = 434,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       line_i,
   output logic       byte_valid_o,
   output logic [7:0] byte_o
);

   localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
   localparam int HALF  = CLKS_PER_BIT / 2;

   if (CLKS_PER_BIT < 4) begin : g_bad_bit_time
      $error("ubl_rx: CLKS_PER_BIT must be at least 4");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("ubl_rx: SYNC_STAGES must not be negative");
   end

   logic line;

   if (SYNC_STAGES == 0) begin : g_no_sync
      assign line = line_i;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sync_q <= 1'b1;
         else         sync_q <= line_i;
      end
      assign line = sync_q;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sync_q <= '1;
         else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      end
      assign line = sync_q[SYNC_STAGES-1];
   end

   rx_state_e  state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [2:0] bit_q;
   logic [7:0] shift_q;
   logic       valid_q;
   logic [7:0] byte_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= RX_WAIT;
         cnt_q   <= '0;
         bit_q   <= '0;
         shift_q <= '0;
         valid_q <= 1'b0;
         byte_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         unique case (state_q)
            RX_WAIT: begin
               cnt_q <= '0;
               if (!line) state_q <= RX_START;
            end
            RX_START: begin
               if (cnt_q == CNT_W'(HALF - 1)) begin
                  cnt_q <= '0;
                  if (!line) begin
                     state_q <= RX_BITS;
                     bit_q   <= '0;
                  end else begin
                     state_q <= RX_WAIT;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            RX_BITS: begin
               if (cnt_q == CNT_W'(CLKS_PER_BIT - 1)) begin
                  cnt_q   <= '0;
                  shift_q <= {line, shift_q[7:1]};
                  if (bit_q == 3'd7) state_q <= RX_STOP;
                  else               bit_q   <= bit_q + 3'd1;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            RX_STOP: begin
               if (cnt_q == CNT_W'(CLKS_PER_BIT - 1)) begin
                  cnt_q   <= '0;
                  state_q <= RX_WAIT;
                  if (line) begin
                     valid_q <= 1'b1;
                     byte_q  <= shift_q;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= RX_WAIT;
         endcase
      end
   end

   assign byte_valid_o = valid_q;
   assign byte_o       = byte_q;

endmodule

// File: rtl/ubl_word_asm.sv
module ubl_word_asm #(
   parameter int WORD_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              valid_i,
   input  logic [7:0]        byte_i,
   output logic              done_o,
   output logic [WORD_W-1:0] word_o
);

   localparam int BYTES = WORD_W / 8;
   localparam int IDX_W = $clog2(BYTES);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

   if (WORD_W % 8 != 0 || BYTES < 2) begin : g_bad_width
      $error("ubl_word_asm: WORD_W must be a multiple of 8 and at least 16");
   end

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       idx_q <= '0;
      else if (clear_i)                  idx_q <= '0;
      else if (valid_i && idx_q == LAST) idx_q <= '0;
      else if (valid_i)                  idx_q <= idx_q + IDX_W'(1);
   end

   for (genvar j = 0; j < BYTES - 1; j++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                              lane_q <= '0;
         else if (valid_i && idx_q == IDX_W'(j))   lane_q <= byte_i;
      end
      assign word_o[8*j +: 8] = lane_q;
   end

   assign word_o[WORD_W-1 -: 8] = byte_i;
   assign done_o                = valid_i && (idx_q == LAST);

endmodule

// File: rtl/uart_boot_loader.sv
module uart_boot_loader
   import ubl_pkg::*;
#(
   parameter int                 CLK_HZ       = 50_000_000,
   parameter int                 BAUD         = 115_200,
   parameter int                 KEY_LEN      = 9,
   parameter logic [8*KEY_LEN-1:0] UNLOCK_KEY = "LOADIMAGE",
   parameter int                 ADDR_W       = 32,
   parameter int                 WORD_W       = 32,
   parameter logic [ADDR_W-1:0]  BASE_ADDR    = 'h8000_0000,
   parameter int                 FINISH_DELAY = 16,
   parameter int                 SYNC_STAGES  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              uart_rx_i,
   output logic              ram_we_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic [WORD_W-1:0] ram_wdata_o,
   output logic              sys_rst_no,
   output logic              busy_o
);

   localparam int CLKS_PER_BIT   = CLK_HZ / BAUD;
   localparam int BYTES_PER_WORD = WORD_W / 8;
   localparam int KEY_IW         = $clog2(KEY_LEN);
   localparam int DLY_W          = $clog2(FINISH_DELAY + 1);
   localparam logic [KEY_IW-1:0] KEY_LAST = KEY_IW'(KEY_LEN - 1);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BYTES_PER_WORD);

   if (KEY_LEN < 2) begin : g_bad_key
      $error("uart_boot_loader: KEY_LEN must be at least 2");
   end
   if (FINISH_DELAY < 1) begin : g_bad_delay
      $error("uart_boot_loader: FINISH_DELAY must be at least 1");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("uart_boot_loader: ADDR_W too small");
   end

   function automatic logic [7:0] key_char(input int i);
      return UNLOCK_KEY[8*(KEY_LEN-1-i) +: 8];
   endfunction

   logic       rx_valid;
   logic [7:0] rx_byte;

   ubl_rx #(
      .CLKS_PER_BIT(CLKS_PER_BIT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_i      (uart_rx_i),
      .byte_valid_o(rx_valid),
      .byte_o      (rx_byte)
   );

   ld_state_e         state_q, state_d;
   logic [KEY_IW-1:0] key_idx_q;
   logic [WORD_W-1:0] words_left_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [DLY_W-1:0]  dly_q;
   logic              rst_n_q;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;

   logic              asm_valid, asm_clear, word_done;
   logic [WORD_W-1:0] asm_word;

   assign asm_valid = rx_valid && (state_q == ST_COUNT || state_q == ST_LOAD);
   assign asm_clear = (state_d == ST_COUNT && state_q != ST_COUNT) ||
                      (state_d == ST_LOAD  && state_q != ST_LOAD);

   ubl_word_asm #(
      .WORD_W(WORD_W)
   ) u_asm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(asm_clear),
      .valid_i(asm_valid),
      .byte_i (rx_byte),
      .done_o (word_done),
      .word_o (asm_word)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (rx_valid && rx_byte == key_char(0)) state_d = ST_KEY;
         end
         ST_KEY: begin
            if (rx_valid) begin
               if (rx_byte != key_char(int'(key_idx_q))) state_d = ST_IDLE;
               else if (key_idx_q == KEY_LAST)           state_d = ST_COUNT;
            end
         end
         ST_COUNT: begin
            if (word_done) state_d = (asm_word == '0) ? ST_DRAIN : ST_LOAD;
         end
         ST_LOAD: begin
            if (word_done && words_left_q == WORD_W'(1)) state_d = ST_DRAIN;
         end
         ST_DRAIN: begin
            if (dly_q == DLY_W'(FINISH_DELAY - 1)) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         key_idx_q    <= '0;
         words_left_q <= '0;
         wr_addr_q    <= BASE_ADDR;
         dly_q        <= '0;
         rst_n_q      <= 1'b1;
         we_q         <= 1'b0;
         addr_q       <= '0;
         wdata_q      <= '0;
      end else begin
         state_q <= state_d;
         rst_n_q <= (state_d == ST_IDLE);
         we_q    <= 1'b0;

         if (state_q == ST_IDLE)                key_idx_q <= KEY_IW'(1);
         else if (state_q == ST_KEY && rx_valid) key_idx_q <= key_idx_q + KEY_IW'(1);

         if (state_q == ST_DRAIN) dly_q <= dly_q + DLY_W'(1);
         else                     dly_q <= '0;

         if (state_q == ST_COUNT && word_done) begin
            words_left_q <= asm_word;
            wr_addr_q    <= BASE_ADDR;
         end

         if (state_q == ST_LOAD && word_done) begin
            words_left_q <= words_left_q - WORD_W'(1);
            wr_addr_q    <= wr_addr_q + STEP;
            we_q         <= 1'b1;
            addr_q       <= wr_addr_q;
            wdata_q      <= asm_word;
         end
      end
   end

   assign ram_we_o    = we_q;
   assign ram_addr_o  = addr_q;
   assign ram_wdata_o = wdata_q;
   assign sys_rst_no  = rst_n_q;
   assign busy_o      = (state_q != ST_IDLE);

endmodule

// File: rtl/ubl_chk.sv
module ubl_chk #(
   parameter int                ADDR_W         = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR      = 'h8000_0000,
   parameter int                BYTES_PER_WORD = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              ram_we_i,
   input logic [ADDR_W-1:0] ram_addr_i,
   input logic              sys_rst_n_i,
   input logic              busy_i
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES_PER_WORD);

   logic              have_q;
   logic [ADDR_W-1:0] last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         have_q <= 1'b0;
         last_q <= '0;
      end else begin
         if (!busy_i)       have_q <= 1'b0;
         else if (ram_we_i) have_q <= 1'b1;
         if (ram_we_i)      last_q <= ram_addr_i;
      end
   end

   AST_FIRST_WORD_AT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ram_we_i && !have_q |-> ram_addr_i == BASE_ADDR); // R5
   AST_WORD_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ram_we_i && have_q |-> ram_addr_i == last_q + STEP); // R5
   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ram_we_i |=> !ram_we_i); // R6
   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ram_we_i |-> busy_i); // R6
   AST_RESET_TRACKS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sys_rst_n_i == !busy_i); // R8

endmodule

bind uart_boot_loader ubl_chk #(
   .ADDR_W        (ADDR_W),
   .BASE_ADDR     (BASE_ADDR),
   .BYTES_PER_WORD(BYTES_PER_WORD)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ram_we_i   (ram_we_o),
   .ram_addr_i (ram_addr_o),
   .sys_rst_n_i(sys_rst_no),
   .busy_i     (busy_o)
);

// File: tb/uart_boot_loader_test.sv
`timescale 1ns/1ps
module uart_boot_loader_test;

   localparam int CPB = 8;
   localparam int FD  = 16;
   localparam logic [71:0] KEY  = "LOADIMAGE";
   localparam logic [31:0] BASE = 32'h8000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic        ram_we;
   logic [31:0] ram_addr, ram_wdata;
   logic        sys_rst_n, busy;

   always #2.5 clk = ~clk;

   uart_boot_loader #(
      .CLK_HZ      (CPB * 115_200),
      .BAUD        (115_200),
      .FINISH_DELAY(FD)
   ) uut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .uart_rx_i  (rx),
      .ram_we_o   (ram_we),
      .ram_addr_o (ram_addr),
      .ram_wdata_o(ram_wdata),
      .sys_rst_no (sys_rst_n),
      .busy_o     (busy)
   );

   int checks = 0;
   int errors = 0;
   int wr_seen = 0;
   logic [31:0] exp_addr[$];
   logic [31:0] exp_data[$];
   bit  armed = 0;
   int  since = 0;
   logic prev_we = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] kc(input int i);
      return KEY[8*(8-i) +: 8];
   endfunction

   // reference model: expected write queue, reset release window, port relations
   always @(negedge clk) begin
      if (rst_n) begin
         check(sys_rst_n == !busy, "R8 reset/busy relation", sys_rst_n, !busy);
         if (ram_we) check(!prev_we, "R6 strobe width", prev_we, 0);
         if (ram_we) check(busy, "R6 strobe while busy", busy, 1);
         if (armed) begin
            since++;
            if (since == FD - 1) check(sys_rst_n == 1'b0, "R7 reset held", sys_rst_n, 0);
            if (since == FD) begin
               check(sys_rst_n == 1'b1, "R7 reset released", sys_rst_n, 1);
               armed = 0;
            end
         end
         if (ram_we) begin
            wr_seen++;
            if (exp_addr.size() == 0) begin
               check(0, "R6 unexpected write", ram_addr, 0);
            end else begin
               logic [31:0] ea, ed;
               ea = exp_addr.pop_front();
               ed = exp_data.pop_front();
               check(ram_addr == ea, "R5 address", ram_addr, ea);
               check(ram_wdata == ed, "R4 data", ram_wdata, ed);
               if (exp_addr.size() == 0) begin
                  armed = 1;
                  since = 0;
               end
            end
         end
         prev_we = ram_we;
      end
   end

   task automatic hold(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic stop = 1'b1);
      hold(1'b0, CPB);
      for (int i = 0; i < 8; i++) hold(b[i], CPB);
      hold(stop, CPB);
      hold(1'b1, 2 * CPB);
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
   endtask

   task automatic send_key(input int from, input int upto);
      for (int i = from; i <= upto; i++) send_byte(kc(i));
   endtask

   task automatic expect_words(input int n, input logic [31:0] seed);
      for (int i = 0; i < n; i++) begin
         exp_addr.push_back(BASE + 32'(4 * i));
         exp_data.push_back(seed + 32'h0101_0101 * 32'(i) ^ 32'h00C3_5A00);
      end
   endtask

   task automatic send_words(input int n, input logic [31:0] seed);
      for (int i = 0; i < n; i++) send_word(seed + 32'h0101_0101 * 32'(i) ^ 32'h00C3_5A00);
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_sim();
   end

   initial begin
      int base_wr;
      repeat (10) @(negedge clk);
      check(ram_we == 1'b0, "R6 reset state strobe", ram_we, 0);
      check(sys_rst_n == 1'b1, "R7 reset state", sys_rst_n, 1);
      check(busy == 1'b0, "R8 reset state busy", busy, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: first character enters matching
      send_byte(kc(0));
      check(busy == 1'b1, "R1 busy after first char", busy, 1);
      check(sys_rst_n == 1'b0, "R1 reset asserted", sys_rst_n, 0);
      // R2: mismatch aborts
      send_key(1, 2);
      send_byte(8'h58);
      check(busy == 1'b0, "R2 idle after mismatch", busy, 0);
      check(sys_rst_n == 1'b1, "R2 reset released", sys_rst_n, 1);
      check(wr_seen == 0, "R2 no write", wr_seen, 0);

      // R11: zero count
      send_key(0, 8);
      send_word(32'h0);
      hold(1'b1, FD + 20);
      check(wr_seen == 0, "R11 no write on zero count", wr_seen, 0);
      check(busy == 1'b0 && sys_rst_n == 1'b1, "R11 back to idle", busy, 0);

      // R3/R4/R5: three words, count LSB first
      base_wr = wr_seen;
      expect_words(3, 32'hDEAD_BEEF);
      send_key(0, 8);
      send_word(32'd3);
      check(busy == 1'b1 && sys_rst_n == 1'b0, "R7 reset held during load", sys_rst_n, 0);
      send_words(3, 32'hDEAD_BEEF);
      hold(1'b1, FD + 20);
      check(wr_seen - base_wr == 3, "R3 write count", wr_seen - base_wr, 3);
      check(exp_addr.size() == 0, "R3 all words written", exp_addr.size(), 0);

      // R5: second load restarts at base
      base_wr = wr_seen;
      expect_words(2, 32'h1357_9BDF);
      send_key(0, 8);
      send_word(32'd2);
      send_words(2, 32'h1357_9BDF);
      hold(1'b1, FD + 20);
      check(wr_seen - base_wr == 2, "R5 second load count", wr_seen - base_wr, 2);
      check(busy == 1'b0, "R7 idle after load", busy, 0);

      // R9: short glitch mid-string is dropped
      base_wr = wr_seen;
      expect_words(1, 32'h7E81_0246);
      send_key(0, 3);
      hold(1'b0, 2);
      hold(1'b1, 12 * CPB);
      send_key(4, 8);
      send_word(32'd1);
      send_words(1, 32'h7E81_0246);
      hold(1'b1, FD + 20);
      check(wr_seen - base_wr == 1, "R9 false start ignored", wr_seen - base_wr, 1);

      // R10: frame with low stop bit is discarded
      base_wr = wr_seen;
      expect_words(1, 32'h0F1E_2D3C);
      send_key(0, 3);
      send_byte(kc(4), 1'b0);
      hold(1'b1, 12 * CPB);
      send_key(4, 8);
      send_word(32'd1);
      send_words(1, 32'h0F1E_2D3C);
      hold(1'b1, FD + 20);
      check(wr_seen - base_wr == 1, "R10 bad stop frame dropped", wr_seen - base_wr, 1);
      check(exp_addr.size() == 0, "R10 queue drained", exp_addr.size(), 0);

      finish_sim();
   end

endmodule